// File: doc/BRIEF.md
# Memory Training Sequencer with Status Word

This block sequences the top level of memory-interface training. A training command starts a fixed walk through four phases. The phases are read data-to-strobe alignment, receive-enable bit lock, write leveling and write data-to-strobe alignment. Each phase is run by an external phase engine through a start pulse and a done pulse that carries a pass/fail bit. The sequencer keeps one pass flag for each phase. When the walk is over it raises a completion flag, whether or not the phases passed.

Two calibration commands are tracked next to the training walk: impedance compensation and long ZQ calibration. Each has its own start/done handshake and its own completion flag. All of this state, together with the live sequencer state code, is shown in one read-only status word. A new training command wipes the training part of that word.

Top module: `mtrn_seq_top`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, the status word reads zero and no start output is high.
- R2: A training command sampled in idle moves the state field (status bits 2:0) to 001 one cycle later. In that cycle it pulses start bit 0 and shows all four pass flags and the completion flag (bit 8) cleared.
- R3: Phases run in state order 001, 010, 011, 100. A done pulse on the bit of the current phase (state code minus one) advances the state one cycle later, and in that cycle it pulses the start bit of the next phase for exactly one cycle.
- R4: The pass flag of phase k (status bit 3+k, k=0..3) takes the pass input of that phase as sampled with its done pulse, and is visible one cycle later.
- R5: The done pulse of the last phase returns the state field to 000 and sets bit 8 one cycle later, even when phases failed.
- R6: A done pulse on a phase bit other than the current phase, or any done pulse in idle, changes nothing in the status word and raises no start output.
- R7: A training command received while the state field is not 000 is ignored.
- R8: A ZQ command accepted in idle clears bit 7 and pulses the ZQ start output one cycle later. The next ZQ done pulse sets bit 7 one cycle after it is sampled.
- R9: An impedance command accepted in idle clears bit 9 and pulses the impedance start output one cycle later. The next impedance done pulse sets bit 9 one cycle after it is sampled. Bit 7 is not affected.
- R10: A calibration command is ignored while training runs or while that same calibration is still waiting for its done pulse.
- R11: Status bits 31 down to 10 always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| train_cmd | input | 1 | Training command strobe |
| zq_cmd | input | 1 | Long ZQ calibration command strobe |
| imp_cmd | input | 1 | Impedance compensation command strobe |
| phase_start | output | 4 | One-cycle start pulse for each training phase |
| phase_done | input | 4 | Done pulse from each phase engine |
| phase_pass | input | 4 | Pass bit of each phase, valid with its done pulse |
| zq_start | output | 1 | Start pulse to the ZQ calibration engine |
| zq_done | input | 1 | Done pulse from the ZQ calibration engine |
| imp_start | output | 1 | Start pulse to the impedance engine |
| imp_done | input | 1 | Done pulse from the impedance engine |
| status_word | output | 32 | Read-only status: state code, pass flags, completion flags |

## Verification
Every result of this block is a register, so each command or done pulse shows up in the status word and the start outputs exactly one clock after the edge that samples it. The bench drives stimuli on the falling edge and holds each for one rising edge. It then checks at the next falling edge, which is the first point where the new value is stable. Start pulses are checked again one cycle later to prove they last one cycle. Ignored stimuli are checked in the same cycle slot, against the word as it was before.

// File: rtl/mtrn_pkg.sv
// Package: shared constants and state type for the training sequencer.
// Assumes the phase count matches the number of non-idle state codes.
package mtrn_pkg;

    localparam int unsigned PHASE_N  = 4;
    localparam int unsigned STATE_W  = $clog2(PHASE_N + 1);
    localparam int unsigned IDX_W    = $clog2(PHASE_N);
    localparam int unsigned CAL_N    = 2;
    localparam int unsigned CAL_ZQ   = 0;
    localparam int unsigned CAL_IMP  = 1;

    // Bit positions in the status word
    localparam int unsigned POS_PASS0 = STATE_W;
    localparam int unsigned POS_ZQ    = POS_PASS0 + PHASE_N;
    localparam int unsigned POS_INIT  = POS_ZQ + 1;
    localparam int unsigned POS_IMP   = POS_INIT + 1;
    localparam int unsigned USED_W    = POS_IMP + 1;

    typedef enum logic [STATE_W-1:0] {
        ST_IDLE  = 3'd0,
        ST_RDDQ  = 3'd1,
        ST_RCVEN = 3'd2,
        ST_WRLVL = 3'd3,
        ST_WRDQ  = 3'd4
    } mtrn_state_e;

endpackage

// File: rtl/mtrn_phase_seq.sv
// Module: mtrn_phase_seq
// Walks through the training phases in state-code order. Each phase gets a
// one-cycle start pulse. The walk waits for that phase's done pulse, keeps the
// pass bit and moves on. After the last phase it returns to idle and sets
// the completion flag.
// Assumes: done/pass pulses are one cycle wide. Training commands outside idle
// are dropped. A new command clears pass flags and completion.
module mtrn_phase_seq
    import mtrn_pkg::*;
#(
    parameter int unsigned NPH = PHASE_N
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              train_cmd,
    input  logic [NPH-1:0]    phase_done,
    input  logic [NPH-1:0]    phase_pass,
    output mtrn_state_e       state,
    output logic [NPH-1:0]    phase_start,
    output logic [NPH-1:0]    pass_flags,
    output logic              init_cmplt
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NPH - 1);

    logic [IDX_W-1:0] cur_idx;
    logic             cur_done;
    logic             is_idle;

    // Decode the index of the phase that is running now.
    always_comb begin
        is_idle  = (state == ST_IDLE);
        cur_idx  = IDX_W'(state - STATE_W'(1));
        cur_done = !is_idle && phase_done[cur_idx];
    end

    // Sequencer state, start pulses, pass flags and completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            phase_start <= '0;
            pass_flags  <= '0;
            init_cmplt  <= 1'b0;
        end else begin
            phase_start <= '0;
            if (is_idle) begin
                if (train_cmd) begin
                    state          <= ST_RDDQ;
                    pass_flags     <= '0;
                    init_cmplt     <= 1'b0;
                    phase_start[0] <= 1'b1;
                end
            end else if (cur_done) begin
                pass_flags[cur_idx] <= phase_pass[cur_idx];
                if (cur_idx == LAST_IDX) begin
                    state      <= ST_IDLE;
                    init_cmplt <= 1'b1;
                end else begin
                    state                    <= mtrn_state_e'(state + STATE_W'(1));
                    phase_start[cur_idx + 1] <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/mtrn_cal_track.sv
// Module: mtrn_cal_track
// Tracks one calibration command. An accepted command clears the completion
// flag, sends a one-cycle start pulse and waits for done. Done then sets the
// completion flag.
// Assumes: 'allow' is high only when the parent sequencer is idle. A
// command while waiting is dropped. Stray done pulses are ignored.
module mtrn_cal_track (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd,
    input  logic allow,
    input  logic done,
    output logic start,
    output logic cmplt
);

    logic busy;
    logic accept;

    // Accept a command only when allowed and not already waiting.
    always_comb accept = cmd && allow && !busy;

    // Handshake state and completion flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            start <= 1'b0;
            cmplt <= 1'b0;
        end else begin
            start <= accept;
            if (accept) begin
                busy  <= 1'b1;
                cmplt <= 1'b0;
            end else if (busy && done) begin
                busy  <= 1'b0;
                cmplt <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/mtrn_status_pack.sv
// Module: mtrn_status_pack
// Puts the state code, pass flags and completion flags together into the
// read-only status word. Unused upper bits are zero.
// Assumes: STATUS_W is at least USED_W.
module mtrn_status_pack
    import mtrn_pkg::*;
#(
    parameter int unsigned STATUS_W = 32
) (
    input  mtrn_state_e          state,
    input  logic [PHASE_N-1:0]   pass_flags,
    input  logic                 zq_cmplt,
    input  logic                 init_cmplt,
    input  logic                 imp_cmplt,
    output logic [STATUS_W-1:0]  word
);

    // Place each field at its fixed position.
    always_comb begin
        word                              = '0;
        word[STATE_W-1:0]                 = state;
        word[POS_PASS0 +: PHASE_N]        = pass_flags;
        word[POS_ZQ]                      = zq_cmplt;
        word[POS_INIT]                    = init_cmplt;
        word[POS_IMP]                     = imp_cmplt;
    end

endmodule

// File: rtl/mtrn_seq_top.sv
// Module: mtrn_seq_top
// Top of the training sequencer. It holds the phase walker and one
// tracker for each calibration command, and builds the status word.
// Assumes: all strobes are synchronous to clk. Reset is synchronous and active low.
module mtrn_seq_top
    import mtrn_pkg::*;
#(
    parameter int unsigned STATUS_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 train_cmd,
    input  logic                 zq_cmd,
    input  logic                 imp_cmd,
    output logic [PHASE_N-1:0]   phase_start,
    input  logic [PHASE_N-1:0]   phase_done,
    input  logic [PHASE_N-1:0]   phase_pass,
    output logic                 zq_start,
    input  logic                 zq_done,
    output logic                 imp_start,
    input  logic                 imp_done,
    output logic [STATUS_W-1:0]  status_word
);

    mtrn_state_e         state;
    logic [PHASE_N-1:0]  pass_flags;
    logic                init_cmplt;
    logic                seq_idle;
    logic [CAL_N-1:0]    cal_cmd;
    logic [CAL_N-1:0]    cal_done;
    logic [CAL_N-1:0]    cal_start;
    logic [CAL_N-1:0]    cal_cmplt;

    mtrn_phase_seq #(.NPH(PHASE_N)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .train_cmd   (train_cmd),
        .phase_done  (phase_done),
        .phase_pass  (phase_pass),
        .state       (state),
        .phase_start (phase_start),
        .pass_flags  (pass_flags),
        .init_cmplt  (init_cmplt)
    );

    // Calibration commands are gated on the idle state.
    always_comb begin
        seq_idle          = (state == ST_IDLE);
        cal_cmd           = '0;
        cal_done          = '0;
        cal_cmd[CAL_ZQ]   = zq_cmd;
        cal_cmd[CAL_IMP]  = imp_cmd;
        cal_done[CAL_ZQ]  = zq_done;
        cal_done[CAL_IMP] = imp_done;
        zq_start          = cal_start[CAL_ZQ];
        imp_start         = cal_start[CAL_IMP];
    end

    for (genvar g = 0; g < CAL_N; g++) begin : g_cal
        mtrn_cal_track u_cal (
            .clk   (clk),
            .rst_n (rst_n),
            .cmd   (cal_cmd[g]),
            .allow (seq_idle),
            .done  (cal_done[g]),
            .start (cal_start[g]),
            .cmplt (cal_cmplt[g])
        );
    end

    mtrn_status_pack #(.STATUS_W(STATUS_W)) u_pack (
        .state      (state),
        .pass_flags (pass_flags),
        .zq_cmplt   (cal_cmplt[CAL_ZQ]),
        .init_cmplt (init_cmplt),
        .imp_cmplt  (cal_cmplt[CAL_IMP]),
        .word       (status_word)
    );

endmodule

// File: rtl/mtrn_seq_chk.sv
// Module: mtrn_seq_chk
// Property checker bound to mtrn_seq_top. It sees only the top-level ports.
module mtrn_seq_chk
    import mtrn_pkg::*;
#(
    parameter int unsigned STATUS_W = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                train_cmd,
    input logic [PHASE_N-1:0]  phase_start,
    input logic [PHASE_N-1:0]  phase_done,
    input logic [PHASE_N-1:0]  phase_pass,
    input logic                zq_start,
    input logic                zq_done,
    input logic                imp_start,
    input logic                imp_done,
    input logic [STATUS_W-1:0] status_word
);

    logic [STATE_W-1:0] st;
    logic               st_idle;
    logic               st_done;

    // Decode state and current-phase done from the port values.
    always_comb begin
        st      = status_word[STATE_W-1:0];
        st_idle = (st == '0);
        st_done = !st_idle && (st <= STATE_W'(PHASE_N)) &&
                  phase_done[IDX_W'(st - STATE_W'(1))];
    end

    a_r11_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        status_word[STATUS_W-1:USED_W] == '0);

    a_r3_state_legal: assert property (@(posedge clk) disable iff (!rst_n)
        st <= STATE_W'(PHASE_N));

    a_r3_start_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(phase_start));

    a_r2_launch: assert property (@(posedge clk) disable iff (!rst_n)
        (st_idle && train_cmd) |=> (st == STATE_W'(1) && phase_start == PHASE_N'(1)
                                    && status_word[POS_INIT] == 1'b0));

    a_r5_finish: assert property (@(posedge clk) disable iff (!rst_n)
        (st == STATE_W'(PHASE_N) && phase_done[PHASE_N-1]) |=>
            (st_idle && status_word[POS_INIT]));

    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_idle && !st_done) |=> $stable(status_word) && phase_start == '0);

    for (genvar k = 0; k < PHASE_N; k++) begin : g_pass
        a_r4_pass_capture: assert property (@(posedge clk) disable iff (!rst_n)
            (st == STATE_W'(k + 1) && phase_done[k]) |=>
                status_word[POS_PASS0 + k] == $past(phase_pass[k]));
    end

    a_r8_zq_clear: assert property (@(posedge clk) disable iff (!rst_n)
        zq_start |-> !status_word[POS_ZQ]);

    a_r8_zq_set: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_word[POS_ZQ]) |-> $past(zq_done));

    a_r9_imp_clear: assert property (@(posedge clk) disable iff (!rst_n)
        imp_start |-> !status_word[POS_IMP]);

    a_r9_imp_set: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_word[POS_IMP]) |-> $past(imp_done));

endmodule

bind mtrn_seq_top mtrn_seq_chk #(.STATUS_W(STATUS_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .train_cmd   (train_cmd),
    .phase_start (phase_start),
    .phase_done  (phase_done),
    .phase_pass  (phase_pass),
    .zq_start    (zq_start),
    .zq_done     (zq_done),
    .imp_start   (imp_start),
    .imp_done    (imp_done),
    .status_word (status_word)
);

// File: tb/mtrn_seq_top_tb_top.sv
`timescale 1ns/1ps
// Directed bench for mtrn_seq_top. Inputs change on falling edges, and
// results are sampled on the falling edge after the edge that registers them.
module mtrn_seq_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        train_cmd = 1'b0;
    logic        zq_cmd = 1'b0;
    logic        imp_cmd = 1'b0;
    logic [3:0]  phase_start;
    logic [3:0]  phase_done = '0;
    logic [3:0]  phase_pass = '0;
    logic        zq_start;
    logic        zq_done = 1'b0;
    logic        imp_start;
    logic        imp_done = 1'b0;
    logic [31:0] status_word;

    int checks = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    mtrn_seq_top dut_i (
        .clk (clk), .rst_n (rst_n), .train_cmd (train_cmd),
        .zq_cmd (zq_cmd), .imp_cmd (imp_cmd),
        .phase_start (phase_start), .phase_done (phase_done),
        .phase_pass (phase_pass), .zq_start (zq_start), .zq_done (zq_done),
        .imp_start (imp_start), .imp_done (imp_done),
        .status_word (status_word)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pulse_done(input int i, input bit p);
        phase_done[i] = 1'b1;
        phase_pass[i] = p;
        step();
        phase_done = '0;
        phase_pass = '0;
    endtask

    // R1: reset state
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) step();
        chk("R1 status in reset", status_word, 32'h0);
        chk("R1 starts in reset", {26'h0, phase_start, zq_start, imp_start}, 32'h0);
        rst_n = 1'b1;
        step();
        chk("R1 status after release", status_word, 32'h0);
    endtask

    // R2..R5, R11: full walk with a given pass pattern
    task automatic t_walk(input logic [3:0] pat);
        logic [31:0] keep;
        keep = status_word & 32'h280;
        train_cmd = 1'b1;
        step();
        train_cmd = 1'b0;
        chk("R2 state after command", status_word & 32'h7, 32'h1);
        chk("R2 start bit 0", {28'h0, phase_start}, 32'h1);
        chk("R2 flags cleared", status_word & 32'h178, 32'h0);
        for (int i = 0; i < 4; i++) begin
            pulse_done(i, pat[i]);
            chk("R4 pass flag", {31'h0, status_word[3 + i]}, {31'h0, pat[i]});
            if (i < 3) begin
                chk("R3 next state", status_word & 32'h7, 32'(i + 2));
                chk("R3 next start", {28'h0, phase_start}, 32'(1 << (i + 1)));
                step();
                chk("R3 start one cycle", {28'h0, phase_start}, 32'h0);
            end
        end
        chk("R5 final word", status_word, keep | 32'h100 | {25'h0, pat, 3'b000});
        chk("R5 no start", {28'h0, phase_start}, 32'h0);
        chk("R11 upper bits", status_word >> 10, 32'h0);
    endtask

    // R6, R7, R10: stimuli that must be ignored
    task automatic t_ignore();
        logic [31:0] snap;
        train_cmd = 1'b1;
        step();
        train_cmd = 1'b0;
        snap = status_word;
        train_cmd = 1'b1;
        step();
        train_cmd = 1'b0;
        chk("R7 retrain ignored", status_word, snap);
        chk("R7 no start", {28'h0, phase_start}, 32'h0);
        pulse_done(2, 1'b1);
        chk("R6 wrong done ignored", status_word, snap);
        chk("R6 wrong done no start", {28'h0, phase_start}, 32'h0);
        zq_cmd = 1'b1;
        imp_cmd = 1'b1;
        step();
        zq_cmd = 1'b0;
        imp_cmd = 1'b0;
        chk("R10 cal ignored in training", {30'h0, zq_start, imp_start}, 32'h0);
        for (int i = 0; i < 4; i++) pulse_done(i, 1'b1);
        snap = status_word;
        chk("R5 walk done", snap & 32'h107, 32'h100);
        pulse_done(0, 1'b0);
        chk("R6 idle done ignored", status_word, snap);
        chk("R6 idle done no start", {28'h0, phase_start}, 32'h0);
    endtask

    // R8: ZQ handshake
    task automatic t_zq();
        zq_cmd = 1'b1;
        step();
        zq_cmd = 1'b0;
        chk("R8 zq start", {31'h0, zq_start}, 32'h1);
        chk("R8 zq flag cleared", {31'h0, status_word[7]}, 32'h0);
        step();
        chk("R8 zq start one cycle", {31'h0, zq_start}, 32'h0);
        zq_cmd = 1'b1;
        step();
        zq_cmd = 1'b0;
        chk("R10 zq busy ignored", {31'h0, zq_start}, 32'h0);
        chk("R8 zq still pending", {31'h0, status_word[7]}, 32'h0);
        zq_done = 1'b1;
        step();
        zq_done = 1'b0;
        chk("R8 zq flag set", {31'h0, status_word[7]}, 32'h1);
    endtask

    // R9: impedance handshake, independent of ZQ
    task automatic t_imp();
        imp_cmd = 1'b1;
        step();
        imp_cmd = 1'b0;
        chk("R9 imp start", {31'h0, imp_start}, 32'h1);
        chk("R9 imp flag cleared", {31'h0, status_word[9]}, 32'h0);
        chk("R9 zq flag untouched", {31'h0, status_word[7]}, 32'h1);
        step();
        chk("R9 imp start one cycle", {31'h0, imp_start}, 32'h0);
        imp_done = 1'b1;
        step();
        imp_done = 1'b0;
        chk("R9 imp flag set", {31'h0, status_word[9]}, 32'h1);
        imp_done = 1'b1;
        step();
        imp_done = 1'b0;
        chk("R9 stray done keeps flag", {31'h0, status_word[9]}, 32'h1);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_walk(4'b1111);
        t_walk(4'b0101);
        t_walk(4'b0000);
        t_ignore();
        t_zq();
        t_imp();
        t_walk(4'b1010);
        chk("R11 cal flags kept by training", status_word & 32'h280, 32'h280);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

endmodule